// File: doc/BRIEF.md
# Byte-Serial Register Write Decoder

This block turns a stream of bytes into register writes. A command comes in one byte per clock on an 8-bit bus. A start flag is raised only with the first byte of each command. The first two bytes carry a 16-bit register address, low byte first. A fixed number of data bytes follows, least significant byte first.

When the last data byte arrives, the block checks the address against a base and mask pair that are set by parameters. If the address falls in the block's window, it raises a one-cycle write pulse. The pulse carries the local register index and the assembled data word, and any register file behind it can use them directly.

A command has at most six bytes. A new start flag always begins a fresh command, even if the previous one is not finished. While no command is in progress, bytes without a start flag are dropped.

Top module: `cmd_byte_deser`

## Requirements
- R1: After synchronous reset `srst`, `wr_pulse`, `wr_addr` and `wr_data` are all 0 and no command is in progress.
- R2: Byte order is fixed. The byte sent with `cmd_first`=1 is address bits [7:0]. The next byte is address bits [15:8]. Data byte k (k = 0 .. DATA_BYTES-1) goes to `wr_data[8k+7:8k]`.
- R3: After the two address bytes, exactly DATA_BYTES data bytes are collected (default 4, range 1 to 4).
- R4: A command writes only when (address & ADDR_MASK) == (BASE_ADDR & ADDR_MASK). With the defaults 0x0738 and 0x07FE, 0x0738, 0x0739 and 0xF738 match, and 0x073A and 0x0538 do not.
- R5: `wr_addr` equals address[LOCAL_W-1:0] & ~ADDR_MASK[LOCAL_W-1:0]. With the defaults, address 0x0739 gives `wr_addr` 0x01.
- R6: For a matching command, `wr_pulse` is high for exactly one cycle. That cycle follows the clock edge that samples the last data byte.
- R7: `wr_addr` and `wr_data` change only together with a write pulse, or on reset. Between writes they hold their values.
- R8: A byte with `cmd_first`=1 that arrives while a command is being assembled drops the old command and starts a new one with that byte as address low. This includes the case where it lands on the old command's last data slot.
- R9: While idle, bytes with `cmd_first`=0 have no effect on any output.
- R10: Asserting `srst` in the middle of a command discards that command. No write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Serial command byte |
| cmd_first | input | 1 | High with the first (address low) byte of a command |
| wr_pulse | output | 1 | One-cycle write strobe |
| wr_addr | output | LOCAL_W | Local register index |
| wr_data | output | 32 | Assembled data word, zero above 8*DATA_BYTES |

## Verification
A byte is sampled on the rising edge after it is driven. The write pulse, address and data all come from registers loaded on the edge that samples the final data byte, so they appear one edge after that byte's sample point. A behavioural model in the bench advances on the same edge from the same inputs. All three outputs are compared with the model at every falling edge, halfway between updates. Each stimulus phase tags its comparisons with the requirement it exercises: aborts, idle noise, reset mid-command, back-to-back commands, and addresses inside and outside the window.

// File: rtl/cmd_byte_deser.sv
module cmd_byte_deser #(
  parameter logic [15:0] BASE_ADDR  = 16'h0738,
  parameter logic [15:0] ADDR_MASK  = 16'h07FE,
  parameter int          DATA_BYTES = 4,
  parameter int          LOCAL_W    = 8
) (
  input  logic               clk,
  input  logic               srst,
  input  logic [7:0]         cmd_byte,
  input  logic               cmd_first,
  output logic               wr_pulse,
  output logic [LOCAL_W-1:0] wr_addr,
  output logic [31:0]        wr_data
);
  localparam int DW    = 8 * DATA_BYTES;
  localparam int LAST  = DATA_BYTES + 1;
  localparam int CNT_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] AHI_C  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       addr_lo, addr_hi;
  logic [DW-1:0]    data_q, data_full;

  wire [15:0] full_addr = {cmd_byte, addr_lo};
  wire [15:0] cur_addr  = {addr_hi, addr_lo};
  wire        at_last   = (cnt == LAST_C) && !cmd_first;
  wire        hit       = (cur_addr & ADDR_MASK) == (BASE_ADDR & ADDR_MASK);

  always_ff @(posedge clk) begin
    if (srst) cnt <= '0;
    else if (cmd_first) cnt <= AHI_C;
    else if (at_last) cnt <= '0;
    else if (cnt != '0) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      addr_lo <= '0;
      addr_hi <= '0;
    end else if (cmd_first) begin
      addr_lo <= cmd_byte;
    end else if (cnt == AHI_C) begin
      addr_hi <= full_addr[15:8];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DATA_BYTES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (srst || cmd_first) data_q[8*g +: 8] <= '0;
        else if (cnt == CNT_W'(g + 2)) data_q[8*g +: 8] <= cmd_byte;
      end
    end
  endgenerate

  always_comb begin
    data_full = data_q;
    data_full[8*(DATA_BYTES-1) +: 8] = cmd_byte;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_pulse <= at_last && hit;
      if (at_last && hit) begin
        wr_addr <= cur_addr[LOCAL_W-1:0] & ~ADDR_MASK[LOCAL_W-1:0];
        wr_data <= 32'(data_full);
      end
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (srst)
    wr_pulse |=> !wr_pulse);
  // R6
  pulse_after_last_chk: assert property (@(posedge clk) disable iff (srst)
    $rose(wr_pulse) |-> ($past(cnt) == LAST_C && !$past(cmd_first)));
  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (srst)
    (!wr_pulse && !$past(srst)) |-> $stable(wr_addr));
  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (srst)
    (!wr_pulse && !$past(srst)) |-> $stable(wr_data));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (srst)
    cmd_first |=> (cnt == AHI_C));
  // R9
  idle_stay_chk: assert property (@(posedge clk) disable iff (srst)
    (cnt == '0 && !cmd_first) |=> (cnt == '0 && !wr_pulse));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (srst)
    cnt <= LAST_C);
  // R10
  reset_idle_chk: assert property (@(posedge clk)
    srst |=> (cnt == '0 && !wr_pulse));
endmodule

// File: tb/cmd_byte_deser_test.sv
module cmd_byte_deser_test;
  localparam int N = 4;
  localparam logic [15:0] BASE = 16'h0738;
  localparam logic [15:0] MASK = 16'h07FE;

  logic clk = 0;
  logic srst = 1;
  logic [7:0] cmd_byte = 0;
  logic cmd_first = 0;
  logic wr_pulse;
  logic [7:0] wr_addr;
  logic [31:0] wr_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit running = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  cmd_byte_deser #(.BASE_ADDR(BASE), .ADDR_MASK(MASK), .DATA_BYTES(N), .LOCAL_W(8)) uut (
    .clk(clk), .srst(srst), .cmd_byte(cmd_byte), .cmd_first(cmd_first),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data));

  int pos = -1;
  logic [15:0] m_a = 0;
  logic [31:0] m_d = 0;
  logic e_pulse = 0;
  logic [7:0] e_addr = 0;
  logic [31:0] e_data = 0;

  always @(posedge clk) begin
    if (srst) begin
      pos = -1; e_pulse = 0; e_addr = 0; e_data = 0;
    end else begin
      e_pulse = 0;
      if (cmd_first) begin
        m_a = {8'h00, cmd_byte}; m_d = 0; pos = 1;
      end else if (pos == 1) begin
        m_a[15:8] = cmd_byte; pos = 2;
      end else if (pos >= 2) begin
        m_d[8*(pos-2) +: 8] = cmd_byte;
        if (pos - 2 == N - 1) begin
          if ((m_a & MASK) == (BASE & MASK)) begin
            e_pulse = 1;
            e_addr = m_a[7:0] & ~MASK[7:0];
            e_data = m_d;
          end
          pos = -1;
        end else pos = pos + 1;
      end
    end
  end

  always @(negedge clk) if (running) begin
    checks += 3;
    if (wr_pulse !== e_pulse) begin
      errors++; $display("FAIL %s wr_pulse actual=%0b expected=%0b", tag, wr_pulse, e_pulse);
    end
    if (wr_addr !== e_addr) begin
      errors++; $display("FAIL %s wr_addr actual=%h expected=%h", tag, wr_addr, e_addr);
    end
    if (wr_data !== e_data) begin
      errors++; $display("FAIL %s wr_data actual=%h expected=%h", tag, wr_data, e_data);
    end
  end

  task automatic put(input logic [7:0] b, input logic f);
    @(negedge clk);
    cmd_byte = b; cmd_first = f;
  endtask

  task automatic cmd(input logic [15:0] a, input logic [31:0] d, input int nd);
    put(a[7:0], 1);
    put(a[15:8], 0);
    for (int i = 0; i < nd; i++) put(d[8*i +: 8], 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(8'(i * 37 + 5), 0);
  endtask

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    running = 1;
    tag = "R1"; idle(2);
    srst = 0;
    idle(2);
    tag = "R2"; cmd(16'h0738, 32'hA1B2C3D4, N); idle(3);
    tag = "R5"; cmd(16'h0739, 32'h01020304, N); idle(3);
    tag = "R4"; cmd(16'hF738, 32'h55AA55AA, N); idle(3);
    tag = "R4"; cmd(16'h073A, 32'hDEADBEEF, N); idle(3);
    tag = "R4"; cmd(16'h0538, 32'h12345678, N); idle(3);
    tag = "R7"; idle(6);
    tag = "R9"; idle(10);
    tag = "R8"; cmd(16'h0738, 32'h99999999, 2); cmd(16'h0739, 32'hCAFEF00D, N); idle(3);
    tag = "R8"; cmd(16'h0738, 32'h77777777, N-1); cmd(16'h0738, 32'h0BADC0DE, N); idle(3);
    tag = "R6"; cmd(16'h0739, 32'h11111111, N); cmd(16'h0738, 32'h22222222, N); idle(4);
    tag = "R3"; cmd(16'h0738, 32'hFFEEDDCC, N); put(8'h44, 0); put(8'h33, 0); idle(3);
    tag = "R10"; cmd(16'h0738, 32'h66666666, 2);
    @(negedge clk); srst = 1; cmd_byte = 8'h66; cmd_first = 0;
    @(negedge clk); srst = 0;
    idle(6);
    tag = "R2"; cmd(16'h0739, 32'h80402010, N); idle(3);
    for (int k = 0; k < 40; k++) begin
      tag = "R4";
      cmd(16'h0730 + 16'(k % 16), 32'(k * 32'h01030507), N);
      idle(k % 3);
    end
    idle(4);
    running = 0;
    done = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end
endmodule